// File: doc/BRIEF.md
# HDLC Receive Deframer

This block sits on the receive side of a bit-synchronous HDLC link. It takes one line bit per rising edge of a receive clock supplied from outside, and finds frame boundaries by watching for the flag octet 0x7E. It deletes the zeros that the far end stuffed into the stream and packs the remaining payload bits into bytes, least significant bit first. Each byte appears on an 8-bit parallel port with a one-cycle strobe. Start-of-frame and end-of-frame markers travel with the data. An end-of-frame marker that closes a frame whose bit count is not a whole number of bytes also raises a misalignment flag.

The same bit stream is watched for line conditions. A run of seven ones inside a frame link is reported as an abort, and the frame in progress is dropped. If the ones continue after a reported abort, the line is flagged as idle. Frame check sequence checking, address matching, buffering and crossing into a system clock domain are left to the logic behind this block.

Internally, each arriving bit is shifted through an eight-slot window. Every slot carries a keep tag. The window is cleared whenever a flag or an abort completes, so no flag bit ever leaks into the payload.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: While reset is held and afterwards, every output is low until the first flag has been seen. Before that flag, no line pattern (including long runs of ones) produces a byte strobe, an end-of-frame pulse or an abort pulse.
- R2: A zero that follows exactly six consecutive ones is a flag. It delimits frames, and none of the eight flag bits reaches the byte output.
- R3: A zero that follows exactly five consecutive ones is removed from the data and is not counted as a data bit.
- R4: Data bits are packed least significant bit first. The first bit received after a flag lands in `byte_o[0]`. One `byte_vld_o` pulse is given for every eight data bits, so a frame carrying the values 0 to 255 is returned unchanged.
- R5: `sof_o` is high together with the `byte_vld_o` of the first byte after a flag, and is low with every other byte.
- R6: A flag that closes a frame holding at least one data bit gives a one-cycle `eof_o` pulse in the cycle after its final zero is sampled. The last complete byte has been delivered by that cycle. `eof_misalign_o` is high with the pulse exactly when the data bit count is not a multiple of eight, and the leftover bits are discarded.
- R7: Two or more flags with no data bits between them produce no `eof_o`.
- R8: Seven consecutive ones arriving after a flag give one `abort_o` pulse in the cycle after the seventh one is sampled. The partly built byte is dropped, and the block returns to hunting for a flag. A later flag and frame are received normally.
- R9: `idle_o` rises in the cycle after the IDLE_RUN-th consecutive one (default 15), but only when an abort has been reported since the last flag. It stays high while ones continue and falls after the next zero. Ones seen before any abort never raise it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_rx | input | 1 | Receive bit clock from the line side; one line bit per rising edge |
| rst_rx_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| line_i | input | 1 | Serial line data |
| byte_o | output | 8 | Received payload byte |
| byte_vld_o | output | 1 | One-cycle strobe qualifying `byte_o` |
| sof_o | output | 1 | Marks the first byte of a frame |
| eof_o | output | 1 | One-cycle end-of-frame pulse |
| eof_misalign_o | output | 1 | Frame ended on a non-byte boundary; valid with `eof_o` |
| abort_o | output | 1 | One-cycle abort pulse |
| idle_o | output | 1 | Line idle (ones) after an abort |

## Verification
Every result is registered one edge after the line bit that decides it. `eof_o` is due in the cycle after the closing flag's final zero. `abort_o` is due after the seventh one, and `idle_o` after the IDLE_RUN-th one. A byte strobe comes one cycle after the line bit that pushes that byte's last data bit out of the eight-slot window, which is never later than the closing flag. The bench drives one bit per clock and samples 1 ns after the edge that takes it. Events are compared in order against an expected list built from the stuffed bit stream. Right after each closing flag and each seventh one, the bench checks that this list is empty, so a marker that arrives late or early is reported.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  localparam int FLAG_LEN  = 8;
  localparam int STUFF_RUN = 5;
  localparam int FLAG_RUN  = 6;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_OPEN = 2'd1,
    ST_DATA = 2'd2
  } frm_state_e;

endpackage

// File: rtl/hdlc_rx_run_det.sv
module hdlc_rx_run_det
  import hdlc_rx_pkg::*;
#(
  parameter int unsigned IDLE_RUN = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_i,
  output logic flag_o,
  output logic stuff_o,
  output logic abort_o,
  output logic long_run_o
);

  localparam int CW = $clog2(IDLE_RUN + 1);

  logic [CW-1:0] run_q, run_d;

  always_comb begin
    if (bit_i) begin
      run_d = (run_q == CW'(IDLE_RUN)) ? run_q : run_q + CW'(1);
    end else begin
      run_d = '0;
    end
  end

  // zero after six ones closes a flag, after five ones it is stuffing
  assign flag_o     = !bit_i && (run_q == CW'(FLAG_RUN));
  assign stuff_o    = !bit_i && (run_q == CW'(STUFF_RUN));
  // seventh one in a row
  assign abort_o    =  bit_i && (run_q == CW'(FLAG_RUN));
  assign long_run_o = (run_d == CW'(IDLE_RUN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else begin
      run_q <= run_d;
    end
  end

endmodule

// File: rtl/hdlc_rx_window.sv
module hdlc_rx_window #(
  parameter int DEPTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_i,
  input  logic keep_i,
  input  logic clear_i,
  output logic tail_bit_o,
  output logic tail_keep_o
);

  logic [DEPTH-1:0] dat_q, dat_d;
  logic [DEPTH-1:0] kep_q, kep_d;

  always_comb begin
    dat_d = {dat_q[DEPTH-2:0], bit_i};
    if (clear_i) begin
      kep_d = '0;
    end else begin
      kep_d = {kep_q[DEPTH-2:0], keep_i};
    end
  end

  assign tail_bit_o  = dat_q[DEPTH-1];
  assign tail_keep_o = kep_q[DEPTH-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
      kep_q <= '0;
    end else begin
      dat_q <= dat_d;
      kep_q <= kep_d;
    end
  end

endmodule

// File: rtl/hdlc_rx_assembler.sv
module hdlc_rx_assembler
  import hdlc_rx_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_i,
  input  logic              bit_vld_i,
  input  logic              flag_i,
  input  logic              run7_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_vld_o,
  output logic              sof_o,
  output logic              eof_o,
  output logic              eof_misalign_o,
  output logic              abort_o,
  output logic              abort_evt_o
);

  localparam int IW = $clog2(BYTE_W);

  frm_state_e        state_q, state_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic              first_q, first_d;
  logic [BYTE_W-1:0] byte_q, byte_d;
  logic              vld_q, vld_d;
  logic              sof_q, sof_d;
  logic              eof_q, eof_d;
  logic              mis_q, mis_d;
  logic              abt_q, abt_d;
  logic              take;
  logic              in_frame;

  always_comb begin
    state_d = state_q;
    sh_d    = sh_q;
    idx_d   = idx_q;
    first_d = first_q;
    byte_d  = byte_q;
    vld_d   = 1'b0;
    sof_d   = 1'b0;
    eof_d   = 1'b0;
    mis_d   = 1'b0;
    abt_d   = 1'b0;

    take     = bit_vld_i && (state_q != ST_HUNT) && !run7_i;
    in_frame = (state_q == ST_DATA) || take;

    if (take) begin
      sh_d    = {bit_i, sh_q[BYTE_W-1:1]};
      state_d = ST_DATA;
      if (idx_q == IW'(BYTE_W - 1)) begin
        byte_d  = sh_d;
        vld_d   = 1'b1;
        sof_d   = first_q;
        first_d = 1'b0;
        idx_d   = '0;
      end else begin
        idx_d = idx_q + IW'(1);
      end
    end

    if (run7_i && (state_q != ST_HUNT)) begin
      abt_d   = 1'b1;
      state_d = ST_HUNT;
      idx_d   = '0;
    end else if (flag_i) begin
      if (in_frame) begin
        eof_d = 1'b1;
        mis_d = (idx_d != '0);
      end
      state_d = ST_OPEN;
      idx_d   = '0;
      first_d = 1'b1;
    end
  end

  assign abort_evt_o    = abt_d;
  assign byte_o         = byte_q;
  assign byte_vld_o     = vld_q;
  assign sof_o          = sof_q;
  assign eof_o          = eof_q;
  assign eof_misalign_o = mis_q;
  assign abort_o        = abt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      sh_q    <= '0;
      idx_q   <= '0;
      first_q <= 1'b1;
      byte_q  <= '0;
      vld_q   <= 1'b0;
      sof_q   <= 1'b0;
      eof_q   <= 1'b0;
      mis_q   <= 1'b0;
      abt_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      sh_q    <= sh_d;
      idx_q   <= idx_d;
      first_q <= first_d;
      byte_q  <= byte_d;
      vld_q   <= vld_d;
      sof_q   <= sof_d;
      eof_q   <= eof_d;
      mis_q   <= mis_d;
      abt_q   <= abt_d;
    end
  end

endmodule

// File: rtl/hdlc_rx_idle.sv
module hdlc_rx_idle (
  input  logic clk,
  input  logic rst_n,
  input  logic abort_evt_i,
  input  logic flag_i,
  input  logic long_run_i,
  output logic idle_o
);

  logic armed_q, armed_d;
  logic idle_q, idle_d;

  always_comb begin
    armed_d = armed_q;
    if (abort_evt_i) begin
      armed_d = 1'b1;
    end else if (flag_i) begin
      armed_d = 1'b0;
    end
    idle_d = (armed_q || abort_evt_i) && long_run_i;
  end

  assign idle_o = idle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      idle_q  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      idle_q  <= idle_d;
    end
  end

endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
#(
  parameter int          BYTE_W   = 8,
  parameter int unsigned IDLE_RUN = 15
) (
  input  logic              clk_rx,
  input  logic              rst_rx_n,
  input  logic              line_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_vld_o,
  output logic              sof_o,
  output logic              eof_o,
  output logic              eof_misalign_o,
  output logic              abort_o,
  output logic              idle_o
);

  logic rst_meta_q, rst_sync_q;
  logic flag_w, stuff_w, run7_w, long_w;
  logic tail_bit_w, tail_keep_w;
  logic abort_evt_w;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_rx or negedge rst_rx_n) begin
    if (!rst_rx_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  hdlc_rx_run_det #(.IDLE_RUN(IDLE_RUN)) u_run (
    .clk        (clk_rx),
    .rst_n      (rst_sync_q),
    .bit_i      (line_i),
    .flag_o     (flag_w),
    .stuff_o    (stuff_w),
    .abort_o    (run7_w),
    .long_run_o (long_w)
  );

  hdlc_rx_window #(.DEPTH(FLAG_LEN)) u_win (
    .clk         (clk_rx),
    .rst_n       (rst_sync_q),
    .bit_i       (line_i),
    .keep_i      (!stuff_w),
    .clear_i     (flag_w || run7_w),
    .tail_bit_o  (tail_bit_w),
    .tail_keep_o (tail_keep_w)
  );

  hdlc_rx_assembler #(.BYTE_W(BYTE_W)) u_asm (
    .clk            (clk_rx),
    .rst_n          (rst_sync_q),
    .bit_i          (tail_bit_w),
    .bit_vld_i      (tail_keep_w),
    .flag_i         (flag_w),
    .run7_i         (run7_w),
    .byte_o         (byte_o),
    .byte_vld_o     (byte_vld_o),
    .sof_o          (sof_o),
    .eof_o          (eof_o),
    .eof_misalign_o (eof_misalign_o),
    .abort_o        (abort_o),
    .abort_evt_o    (abort_evt_w)
  );

  hdlc_rx_idle u_idle (
    .clk         (clk_rx),
    .rst_n       (rst_sync_q),
    .abort_evt_i (abort_evt_w),
    .flag_i      (flag_w),
    .long_run_i  (long_w),
    .idle_o      (idle_o)
  );

endmodule

// File: rtl/hdlc_rx_deframer_chk.sv
module hdlc_rx_deframer_chk (
  input logic clk_rx,
  input logic rst_rx_n,
  input logic line_i,
  input logic byte_vld_o,
  input logic sof_o,
  input logic eof_o,
  input logic eof_misalign_o,
  input logic abort_o,
  input logic idle_o
);

  assert_sof_with_byte_R5: assert property (@(posedge clk_rx) disable iff (!rst_rx_n)
    sof_o |-> byte_vld_o);

  assert_misalign_in_eof_R6: assert property (@(posedge clk_rx) disable iff (!rst_rx_n)
    eof_misalign_o |-> eof_o);

  assert_eof_single_R6: assert property (@(posedge clk_rx) disable iff (!rst_rx_n)
    eof_o |=> !eof_o);

  assert_eof_after_zero_R2: assert property (@(posedge clk_rx) disable iff (!rst_rx_n)
    eof_o |-> !$past(line_i));

  assert_abort_after_one_R8: assert property (@(posedge clk_rx) disable iff (!rst_rx_n)
    abort_o |-> $past(line_i));

  assert_abort_not_eof_R8: assert property (@(posedge clk_rx) disable iff (!rst_rx_n)
    !(abort_o && eof_o));

  assert_idle_on_ones_R9: assert property (@(posedge clk_rx) disable iff (!rst_rx_n)
    idle_o |-> $past(line_i));

endmodule

bind hdlc_rx_deframer hdlc_rx_deframer_chk u_chk (
  .clk_rx         (clk_rx),
  .rst_rx_n       (rst_rx_n),
  .line_i         (line_i),
  .byte_vld_o     (byte_vld_o),
  .sof_o          (sof_o),
  .eof_o          (eof_o),
  .eof_misalign_o (eof_misalign_o),
  .abort_o        (abort_o),
  .idle_o         (idle_o)
);

// File: tb/sim_hdlc_rx_deframer.sv
`timescale 1ns/1ps
module sim_hdlc_rx_deframer;

  logic       clk_rx = 1'b0;
  logic       rst_rx_n;
  logic       line_i;
  logic [7:0] byte_o;
  logic       byte_vld_o, sof_o, eof_o, eof_misalign_o, abort_o, idle_o;

  always #5 clk_rx = ~clk_rx;

  hdlc_rx_deframer u0 (
    .clk_rx         (clk_rx),
    .rst_rx_n       (rst_rx_n),
    .line_i         (line_i),
    .byte_o         (byte_o),
    .byte_vld_o     (byte_vld_o),
    .sof_o          (sof_o),
    .eof_o          (eof_o),
    .eof_misalign_o (eof_misalign_o),
    .abort_o        (abort_o),
    .idle_o         (idle_o)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  int    n_evt = 0;
  int    st_ones = 0;
  int    exp_q[$];
  int    fb[$];
  string cur_req = "R1";
  bit    done = 0;

  // event encoding: kind * 512 + value
  localparam int K_BYTE = 1, K_EOF = 2, K_ABT = 3;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int pop_exp();
    if (exp_q.size() == 0) return -1;
    return exp_q.pop_front();
  endfunction

  task automatic observe();
    int e;
    if (byte_vld_o) begin
      n_evt++;
      e = pop_exp();
      chk(e == K_BYTE * 512 + {sof_o, byte_o}, {cur_req, " R4 R5 byte"},
          K_BYTE * 512 + {sof_o, byte_o}, e);
    end
    if (eof_o) begin
      n_evt++;
      e = pop_exp();
      chk(e == K_EOF * 512 + eof_misalign_o, {cur_req, " R6 eof"},
          K_EOF * 512 + eof_misalign_o, e);
    end
    if (abort_o) begin
      n_evt++;
      e = pop_exp();
      chk(e == K_ABT * 512, {cur_req, " R8 abort"}, K_ABT * 512, e);
    end
  endtask

  task automatic send_bit(input logic b);
    line_i = b;
    @(posedge clk_rx);
    #1;
    observe();
  endtask

  task automatic put_data_bit(input logic b);
    send_bit(b);
    if (b) begin
      st_ones++;
      if (st_ones == 5) begin
        send_bit(1'b0);
        st_ones = 0;
      end
    end else begin
      st_ones = 0;
    end
  endtask

  task automatic put_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) put_data_bit(v[i]);
  endtask

  task automatic put_flag();
    send_bit(1'b0);
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    send_bit(1'b0);
    st_ones = 0;
  endtask

  // sends fb as payload plus k extra bits from xb, then a closing flag
  task automatic frame_body(input int k, input logic [7:0] xb);
    for (int i = 0; i < fb.size(); i++)
      exp_q.push_back(K_BYTE * 512 + {(i == 0), fb[i][7:0]});
    exp_q.push_back(K_EOF * 512 + (k != 0));
    for (int i = 0; i < fb.size(); i++) put_byte(fb[i][7:0]);
    for (int i = 0; i < k; i++) put_data_bit(xb[i]);
    put_flag();
    chk(exp_q.size() == 0, {cur_req, " R6 eof due after closing flag"}, exp_q.size(), 0);
  endtask

  initial begin
    int base;
    rst_rx_n = 1'b0;
    line_i   = 1'b1;
    repeat (3) @(posedge clk_rx);
    #1;
    chk({byte_vld_o, sof_o, eof_o, eof_misalign_o, abort_o, idle_o} == 6'b0,
        "R1 reset outputs", {byte_vld_o, sof_o, eof_o, eof_misalign_o, abort_o, idle_o}, 0);
    rst_rx_n = 1'b1;
    repeat (4) @(posedge clk_rx);
    #1;

    // R1: no output before the first flag
    cur_req = "R1";
    for (int i = 0; i < 48; i++) send_bit((i % 4) != 0);
    // R9: long ones run with no abort reported
    for (int i = 0; i < 20; i++) begin
      send_bit(1'b1);
      chk(idle_o == 1'b0, "R9 no idle without abort", idle_o, 0);
    end
    chk(n_evt == 0, "R1 silent while hunting", n_evt, 0);

    // R7: repeated flags without data
    cur_req = "R7";
    put_flag(); put_flag(); put_flag();
    chk(n_evt == 0, "R7 empty flags give no eof", n_evt, 0);

    // R4: every byte value in one frame
    cur_req = "R4";
    fb.delete();
    for (int v = 0; v < 256; v++) fb.push_back(v);
    frame_body(0, 8'h00);

    // R3: stuffing-heavy frames of lengths 1..6, sharing flags
    cur_req = "R3";
    for (int n = 1; n <= 6; n++) begin
      fb.delete();
      for (int i = 0; i < n; i++) begin
        case (i % 4)
          0: fb.push_back(8'hFF);
          1: fb.push_back(8'h7E);
          2: fb.push_back(8'hFC);
          default: fb.push_back(8'h3F);
        endcase
      end
      frame_body(0, 8'h00);
    end

    cur_req = "R7";
    base = n_evt;
    put_flag(); put_flag();
    chk(n_evt == base, "R7 flags between frames", n_evt - base, 0);

    // R6: trailing 1..7 bits, plus a frame of three bits only
    cur_req = "R6";
    for (int k = 1; k <= 7; k++) begin
      fb.delete();
      fb.push_back(8'hC3);
      fb.push_back(8'h5A);
      frame_body(k, 8'hFF);
    end
    fb.delete();
    frame_body(3, 8'h05);
    fb.delete();
    fb.push_back(8'h81);
    frame_body(0, 8'h00);

    // R8: abort in a frame drops the partial byte
    cur_req = "R8";
    exp_q.push_back(K_BYTE * 512 + {1'b1, 8'hA5});
    exp_q.push_back(K_BYTE * 512 + {1'b0, 8'h3C});
    exp_q.push_back(K_ABT * 512);
    put_byte(8'hA5);
    put_byte(8'h3C);
    put_byte(8'h11);
    for (int i = 1; i <= 7; i++) send_bit(1'b1);
    chk(exp_q.size() == 0, "R8 abort due after seventh one", exp_q.size(), 0);

    // R9: idle after the abort
    for (int n = 8; n <= 22; n++) begin
      send_bit(1'b1);
      chk(idle_o == (n >= 15), "R9 idle after ones run", idle_o, (n >= 15));
    end
    send_bit(1'b0);
    chk(idle_o == 1'b0, "R9 idle falls on zero", idle_o, 0);

    // R8: recovery after abort
    cur_req = "R8";
    put_flag();
    fb.delete();
    fb.push_back(8'h42);
    fb.push_back(8'hE7);
    frame_body(0, 8'h00);
    chk(n_evt > 0 && exp_q.size() == 0, "R2 all events consumed", exp_q.size(), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_rx);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule